// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the clock master of a two-channel audio serial link. It divides the system clock into a bit clock, produces the word clock (or, in the DSP framing, a one-bit frame-sync pulse) and shifts a left and a right sample onto a single data line. Every stereo frame is 64 bit-clock periods long, split into two 32-bit channel slots. The framing is one of four: I2S, left-justified, right-justified or DSP frame-sync.

Samples arrive as a left/right pair on a parallel port with a valid/ready handshake and wait in a one-deep holding register. The framing and the active word width (up to 24 bits) are software-neutral inputs. Both are captured together with the next sample pair once per frame, so a frame is never split between two settings. If no new pair is waiting at that moment, the previous pair is sent again and a sticky underrun flag is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: `ser_bclk` is high and low for `HALF_DIV` clock cycles each. There are 64 bit periods per stereo frame. `ser_dout` and `ser_lrclk` change only in the clock cycle in which `ser_bclk` falls.
- R2: Format code 0 (I2S): the word clock is low for the left slot (frame bits 0-31) and high for the right slot (bits 32-63). Each word starts MSB first at slot bit 1.
- R3: Format code 1 (left-justified): the word clock is high for the left slot and low for the right slot. Each word starts MSB first at slot bit 0.
- R4: Format code 2 (right-justified): the word clock is high for the left slot and low for the right slot. Each word ends with its LSB at slot bit 31.
- R5: Format code 3 (DSP): the word clock is high only during frame bit 0. The left word starts MSB first at bit 1 and the right word at bit 33.
- R6: Only the low `cfg_width` bits of each sample are sent, MSB first. Every other bit period of the slot is driven low. A width of 0 or above 24 is treated as 24.
- R7: Format, width and the next sample pair are captured together at the start of the last bit of the preceding frame. A change of `cfg_fmt` or `cfg_width` at any other time has no effect on the frame being sent.
- R8: `s_ready` is high while the holding register is empty. A pair is taken when `s_valid` and `s_ready` are both high at a clock edge. `s_ready` then stays low until that pair moves to the output stage.
- R9: If the holding register is empty when a frame is captured, the previous pair and the newly sampled settings are sent, and `underrun` goes high and stays high until reset.
- R10: During reset `ser_bclk` is high, while `ser_lrclk`, `ser_dout` and `underrun` are low and `s_ready` is high. One lead-in bit period precedes the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_width | input | 5 | Active word width in bits |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| ser_bclk | output | 1 | Bit clock |
| ser_lrclk | output | 1 | Word clock or frame sync |
| ser_dout | output | 1 | Serial data, changes on bit-clock fall |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong bit counter or a wrong capture point shifts the word within its slot, or mixes settings within one frame. This shows on `ser_dout` and `ser_lrclk` within the same 64-bit frame, so the bench compares every bit of every frame against a frame it builds from the requirements. A divider fault breaks the bit period at the next edge of `ser_bclk`. A holding-register fault either repeats a pair one frame early or loses one, which the frame comparison catches. It also shows as `s_ready` staying high on the cycle after a pair is accepted.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } aud_fmt_e;

endpackage

// File: rtl/aud_bclk_gen.sv
// Bit-clock divider: one bit period is 2*HALF_DIV system clocks.
// bit_adv pulses in the cycle that the bit clock falls (a new bit begins).
module aud_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_adv,
  output logic bclk
);

  localparam int PERIOD = 2 * HALF_DIV;
  localparam int DIV_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [DIV_W-1:0] div_q, div_nxt;
  logic             bclk_q, bclk_nxt;

  always_comb begin
    div_nxt  = div_q;
    bclk_nxt = bclk_q;
    bit_adv  = 1'b0;
    if (div_q == DIV_W'(PERIOD - 1)) begin
      div_nxt  = '0;
      bclk_nxt = 1'b0;
      bit_adv  = 1'b1;
    end else begin
      div_nxt = div_q + DIV_W'(1);
      if (div_q == DIV_W'(HALF_DIV - 1)) bclk_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(HALF_DIV);
      bclk_q <= 1'b1;
    end else begin
      div_q  <= div_nxt;
      bclk_q <= bclk_nxt;
    end
  end

  assign bclk = bclk_q;

endmodule

// File: rtl/aud_sample_stage.sv
// One-deep holding register in front of the output-stage sample pair.
module aud_sample_stage #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                take,
  output logic                s_ready,
  output logic [SAMPLE_W-1:0] cur_left,
  output logic [SAMPLE_W-1:0] cur_right,
  output logic                underrun
);

  logic                full_q, full_nxt;
  logic [SAMPLE_W-1:0] hold_l_q, hold_l_nxt, hold_r_q, hold_r_nxt;
  logic [SAMPLE_W-1:0] cur_l_q, cur_l_nxt, cur_r_q, cur_r_nxt;
  logic                und_q, und_nxt;
  logic                accept;

  always_comb begin
    accept     = s_valid && !full_q;
    full_nxt   = full_q;
    hold_l_nxt = hold_l_q;
    hold_r_nxt = hold_r_q;
    cur_l_nxt  = cur_l_q;
    cur_r_nxt  = cur_r_q;
    und_nxt    = und_q;
    if (take) begin
      if (full_q) begin
        cur_l_nxt = hold_l_q;
        cur_r_nxt = hold_r_q;
        full_nxt  = 1'b0;
      end else begin
        und_nxt = 1'b1;
      end
    end
    if (accept) begin
      hold_l_nxt = s_left;
      hold_r_nxt = s_right;
      full_nxt   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
      und_q    <= 1'b0;
    end else begin
      full_q   <= full_nxt;
      hold_l_q <= hold_l_nxt;
      hold_r_q <= hold_r_nxt;
      cur_l_q  <= cur_l_nxt;
      cur_r_q  <= cur_r_nxt;
      und_q    <= und_nxt;
    end
  end

  assign s_ready   = !full_q;
  assign cur_left  = cur_l_q;
  assign cur_right = cur_r_q;
  assign underrun  = und_q;

endmodule

// File: rtl/aud_slot_mapper.sv
// Maps a frame bit index to the data bit and word-clock level of the
// selected framing. Purely combinational; SLOT_BITS must be a power of two.
module aud_slot_mapper
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int IDX_W     = $clog2(2 * SLOT_BITS),
  parameter int WID_W     = $clog2(SAMPLE_W + 1)
) (
  input  logic [IDX_W-1:0]    bit_idx,
  input  aud_fmt_e            fmt,
  input  logic [WID_W-1:0]    width,
  input  logic [SAMPLE_W-1:0] left,
  input  logic [SAMPLE_W-1:0] right,
  output logic                dout,
  output logic                lrclk
);

  localparam int POS_W = $clog2(SLOT_BITS);

  logic                is_right;
  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] word, shifted;
  int                  offset, k;

  always_comb begin
    is_right = bit_idx[IDX_W-1];
    pos      = bit_idx[POS_W-1:0];
    word     = is_right ? right : left;
    unique case (fmt)
      FMT_LJ:  offset = 0;
      FMT_RJ:  offset = SLOT_BITS - int'(width);
      default: offset = 1;
    endcase
    k       = int'(pos) - offset;
    shifted = word >> (int'(width) - 1 - k);
    dout    = 1'b0;
    if (k >= 0 && k < int'(width)) dout = shifted[0];
    unique case (fmt)
      FMT_I2S: lrclk = is_right;
      FMT_DSP: lrclk = (bit_idx == '0);
      default: lrclk = !is_right;
    endcase
  end

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int HALF_DIV  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cfg_fmt,
  input  logic [$clog2(SAMPLE_W+1)-1:0] cfg_width,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [SAMPLE_W-1:0]           s_left,
  input  logic [SAMPLE_W-1:0]           s_right,
  output logic                          ser_bclk,
  output logic                          ser_lrclk,
  output logic                          ser_dout,
  output logic                          underrun
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int WID_W      = $clog2(SAMPLE_W + 1);

  logic                bit_adv, take;
  logic [IDX_W-1:0]    bit_q, bit_nxt;
  aud_fmt_e            fmt_q, fmt_nxt;
  logic [WID_W-1:0]    wid_q, wid_nxt, wid_eff;
  logic [SAMPLE_W-1:0] cur_l, cur_r;
  logic                map_dout, map_lrclk;
  logic                dout_q, dout_nxt, lr_q, lr_nxt;

  aud_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_adv (bit_adv),
    .bclk    (ser_bclk)
  );

  aud_sample_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_left    (s_left),
    .s_right   (s_right),
    .take      (take),
    .s_ready   (s_ready),
    .cur_left  (cur_l),
    .cur_right (cur_r),
    .underrun  (underrun)
  );

  // The mapper sees the index of the bit that is about to start, and the
  // settings in force for it (captured one bit before the frame begins).
  aud_slot_mapper #(
    .SAMPLE_W  (SAMPLE_W),
    .SLOT_BITS (SLOT_BITS),
    .IDX_W     (IDX_W),
    .WID_W     (WID_W)
  ) u_map (
    .bit_idx (bit_nxt),
    .fmt     (fmt_q),
    .width   (wid_q),
    .left    (cur_l),
    .right   (cur_r),
    .dout    (map_dout),
    .lrclk   (map_lrclk)
  );

  always_comb begin
    bit_nxt  = bit_adv ? bit_q + IDX_W'(1) : bit_q;
    take     = bit_adv && (bit_q == IDX_W'(FRAME_BITS - 2));
    wid_eff  = (cfg_width == '0 || cfg_width > WID_W'(SAMPLE_W)) ? WID_W'(SAMPLE_W) : cfg_width;
    fmt_nxt  = take ? aud_fmt_e'(cfg_fmt) : fmt_q;
    wid_nxt  = take ? wid_eff : wid_q;
    dout_nxt = bit_adv ? map_dout : dout_q;
    lr_nxt   = bit_adv ? map_lrclk : lr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= IDX_W'(FRAME_BITS - 2);
      fmt_q  <= FMT_I2S;
      wid_q  <= WID_W'(SAMPLE_W);
      dout_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      bit_q  <= bit_nxt;
      fmt_q  <= fmt_nxt;
      wid_q  <= wid_nxt;
      dout_q <= dout_nxt;
      lr_q   <= lr_nxt;
    end
  end

  assign ser_dout  = dout_q;
  assign ser_lrclk = lr_q;

endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ser_bclk,
  input logic ser_lrclk,
  input logic ser_dout,
  input logic s_valid,
  input logic s_ready,
  input logic underrun
);

  localparam int CW = $clog2(2 * HALF_DIV) + 1;

  logic [CW-1:0] run_q;
  logic          bclk_d, seen_q;

  // Counts samples since the last bit-clock change to time each phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      bclk_d <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      bclk_d <= ser_bclk;
      if (ser_bclk != bclk_d) begin
        run_q  <= '0;
        seen_q <= 1'b1;
      end else if (run_q != '1) begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assert_bclk_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (ser_bclk != bclk_d)) |-> (run_q == CW'(HALF_DIV - 1)));

  assert_dout_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $fell(ser_bclk));

  assert_lrclk_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_lrclk) |-> $fell(ser_bclk));

  assert_hold_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

endmodule

bind aud_serial_tx aud_serial_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_bclk  (ser_bclk),
  .ser_lrclk (ser_lrclk),
  .ser_dout  (ser_dout),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .underrun  (underrun)
);

// File: tb/aud_serial_tx_tb_top.sv
module aud_serial_tx_tb_top;

  localparam int HALF   = 2;
  localparam int NITEMS = 11;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    int          fmt;
    int          w;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_fmt;
  logic [4:0]  cfg_width;
  logic        s_valid, s_ready;
  logic [23:0] s_left, s_right;
  logic        ser_bclk, ser_lrclk, ser_dout, underrun;

  aud_serial_tx #(.SAMPLE_W(24), .SLOT_BITS(32), .HALF_DIV(HALF)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .cfg_width (cfg_width),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_left    (s_left),
    .s_right   (s_right),
    .ser_bclk  (ser_bclk),
    .ser_lrclk (ser_lrclk),
    .ser_dout  (ser_dout),
    .underrun  (underrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    frames_done = 0;
  item_t exp_q[$];
  item_t last_item;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  // Expected frame built from the requirements R2-R6.
  function automatic void build(input item_t e, output logic [63:0] d, output logic [63:0] l);
    int          w, off, k, pos;
    logic [23:0] word, sh;
    w = (e.w == 0 || e.w > 24) ? 24 : e.w;
    for (int b = 0; b < 64; b++) begin
      pos  = b % 32;
      word = (b >= 32) ? e.r : e.l;
      case (e.fmt)
        1:       off = 0;
        2:       off = 32 - w;
        default: off = 1;
      endcase
      k    = pos - off;
      sh   = word >> (w - 1 - k);
      d[b] = (k >= 0 && k < w) ? sh[0] : 1'b0;
      case (e.fmt)
        0:       l[b] = (b >= 32);
        3:       l[b] = (b == 0);
        default: l[b] = (b < 32);
      endcase
    end
  endfunction

  // Driver: pushes one pair at a negedge when the holding register is empty.
  task automatic send(input item_t it);
    while (!s_ready) @(negedge clk);
    cfg_fmt   = 2'(it.fmt);
    cfg_width = 5'(it.w);
    s_left    = it.l;
    s_right   = it.r;
    s_valid   = 1'b1;
    exp_q.push_back(it);
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R8 ready low after accept", 64'(s_ready), 64'd0);
  endtask

  // Monitor: samples each bit at the bit-clock rise and scores whole frames.
  logic        m_prev;
  int          m_bit, m_gap;
  bit          m_first, m_per_ok;
  logic        m_und;
  logic [63:0] m_d, m_l;

  initial begin
    string       tags[4];
    item_t       e;
    bit          rep;
    logic [63:0] ed, el;
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
    m_prev = 1'b1; m_bit = -1; m_gap = 0; m_first = 1'b1; m_per_ok = 1'b1;
    m_und = 1'b0; m_d = '0; m_l = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        m_prev = 1'b1;
      end else begin
        m_gap++;
        if (ser_bclk && !m_prev) begin
          if (!m_first && m_gap != 2 * HALF) m_per_ok = 1'b0;
          m_first = 1'b0;
          m_gap   = 0;
          if (m_bit < 0) begin
            m_bit = 0;  // lead-in bit before the first frame (R10)
          end else begin
            m_d[m_bit] = ser_dout;
            m_l[m_bit] = ser_lrclk;
            if (m_bit == 32) m_und = underrun;
            if (m_bit == 63) begin
              if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                rep = 1'b0;
                last_item = e;
              end else begin
                e = last_item;
                rep = 1'b1;
              end
              build(e, ed, el);
              chk(m_d == ed, {tags[e.fmt], " R6 R7 dout", rep ? " R9 repeat" : ""}, m_d, ed);
              chk(m_l == el, {tags[e.fmt], " lrclk"}, m_l, el);
              chk(m_per_ok, "R1 bit period", 64'(m_per_ok), 64'd1);
              chk(m_und == rep, "R9 underrun flag", 64'(m_und), 64'(rep));
              m_per_ok = 1'b1;
              m_bit = 0;
              frames_done++;
            end else begin
              m_bit++;
            end
          end
        end
        m_prev = ser_bclk;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int    fmts[NITEMS];
    int    wids[NITEMS];
    item_t it;
    fmts = '{0, 1, 2, 3, 0, 2, 1, 3, 2, 0, 1};
    wids = '{24, 24, 24, 24, 16, 16, 20, 8, 1, 0, 30};
    rst_n = 1'b0; s_valid = 1'b0; cfg_fmt = '0; cfg_width = 5'd24;
    s_left = '0; s_right = '0;
    repeat (5) @(negedge clk);
    chk(ser_bclk == 1'b1,  "R10 reset bclk",     64'(ser_bclk),  64'd1);
    chk(ser_lrclk == 1'b0, "R10 reset lrclk",    64'(ser_lrclk), 64'd0);
    chk(ser_dout == 1'b0,  "R10 reset dout",     64'(ser_dout),  64'd0);
    chk(underrun == 1'b0,  "R10 reset underrun", 64'(underrun),  64'd0);
    chk(s_ready == 1'b1,   "R10 reset ready",    64'(s_ready),   64'd1);
    rst_n = 1'b1;
    for (int i = 0; i < NITEMS; i++) begin
      it.l   = 24'hA5C3F1 ^ 24'(i * 1781239);
      it.r   = 24'h3C0F96 ^ 24'(i * 915311);
      it.fmt = fmts[i];
      it.w   = wids[i];
      send(it);
    end
    // No further pairs: two repeated frames follow (R9).
    wait (frames_done >= NITEMS + 2);
    @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun sticky at end", 64'(underrun), 64'd1);
    finish_run();
  end

endmodule